// File: doc/BRIEF.md
# Parallel Display Bus Master (8-bit, 8080-style)

This block sits between an on-chip requester and an external display controller wired over an 8-bit parallel bus with separate active-low read and write strobes. The requester hands it one request at a time over a valid/ready handshake: a 16-bit command word, a 16-bit data word, a 16-bit read, or a pulse on the panel reset pin. Each 16-bit word crosses the bus as two byte strobes. The block drives chip select, the command/data select line and the panel reset pin. It also controls the direction of the data bus and returns the read result as a one-cycle pulse.

All strobe timing comes from cycle counts. The write-low width and the read sample point are given as nanosecond minimums and rounded up against the clock period. The data setup time before a write strobe, the recovery times after each strobe and the reset pulse and recovery are given directly in cycles. The data bus is brought out as a separate output, an output enable and an input, so that a pad cell can join them.

The controller is one state machine with these states: `ST_IDLE` (ready for a request), `ST_CS_LEAD` (chip select asserted, no strobe yet), `ST_WR_SETUP` (byte driven, write strobe high), `ST_WR_LOW` (write strobe low), `ST_WR_HIGH` (write recovery), `ST_RD_LOW` (read strobe low, byte captured at the last cycle), `ST_RD_HIGH` (read recovery), `ST_CS_TRAIL` (chip select still low after the last strobe), `ST_TURN` (bus turnaround after a read), `ST_RST_LOW` (reset pin low) and `ST_RST_WAIT` (panel recovery).

The transitions are:
- IDLE goes to CS_LEAD on an accepted word request, or to RST_LOW on an accepted reset request.
- CS_LEAD goes to WR_SETUP for writes or to RD_LOW for reads.
- WR_SETUP goes to WR_LOW, then to WR_HIGH, each when its count expires.
- WR_HIGH goes back to WR_SETUP after the upper byte, or to CS_TRAIL after the lower byte.
- RD_LOW goes to RD_HIGH when its count expires.
- RD_HIGH goes back to RD_LOW after the upper byte, or to CS_TRAIL after the lower byte.
- CS_TRAIL goes to TURN after a read, or to IDLE otherwise.
- TURN goes to IDLE.
- RST_LOW goes to RST_WAIT, and RST_WAIT goes to IDLE, each when its count expires.

Top module: `par_disp_master`

## Requirements
- R1: After reset, chip select, write strobe, read strobe, command/data select and the panel reset pin are all high. The data output enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A 16-bit write produces exactly two write strobes: bits 15:8 first, then bits 7:0. The byte stays stable while the strobe is low. For the first byte, the bus is driven exactly SETUP_CYC cycles (1) before the strobe falls.
- R3: For opcode 2'b00 (command), the command/data select is low during both strobes. For opcode 2'b01 (data), it is high during both strobes. Once the block is ready again, the line is high.
- R4: Each write strobe is low for ceil(WR_LOW_NS/CLK_NS) cycles (3 by default). Between the two strobes of one word, the strobe stays high for WR_HIGH_CYC + SETUP_CYC cycles (3) with the bus driven.
- R5: Opcode 2'b10 (read) produces two read strobes. Each is low for max(ceil(RD_LOW_NS/CLK_NS), ceil(RD_SAMPLE_NS/CLK_NS)) cycles (13). The bus byte is captured on the clock edge that closes the last low cycle. The first byte forms bits 15:8 of the result and the second byte forms bits 7:0.
- R6: The data output enable is never high while the read strobe is low. After a read, exactly one cycle passes with chip select high before `req_ready` returns. After a write, no such cycle occurs.
- R7: Each read produces exactly one single-cycle `rsp_valid` pulse carrying the assembled word. Writes produce none.
- R8: Chip select is low whenever either strobe is low, and it returns high before the block is ready again.
- R9: Opcode 2'b11 holds the panel reset pin low for RST_LOW_CYC cycles (8) with no strobe and chip select high. The block then stays not-ready for RST_WAIT_CYC cycles (12).
- R10: `req_ready` is low for the whole of a transaction. Holding `req_valid` high during that time causes no extra transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 00 command, 01 data write, 10 read, 11 panel reset |
| req_word | input | 16 | Word to send (ignored for read and reset) |
| rsp_valid | output | 1 | One-cycle pulse with read result |
| rsp_word | output | 16 | Assembled read word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dc_n | output | 1 | Low = command, high = data |
| bus_rst_n | output | 1 | Panel reset, active low |
| bus_d_out | output | 8 | Byte driven onto the bus |
| bus_d_oe | output | 1 | Drive enable for bus_d_out |
| bus_d_in | input | 8 | Byte read from the bus |

## Verification
A wrong state or a wrong byte-select flag shows at the pins within the transaction itself. The result is a third or a missing strobe, bytes in swapped order, or a strobe whose low width differs from its count, all visible at the next rising edge of the strobe. The bench models the panel and feeds deliberately wrong bytes on the read bus until the sample cycle, so a capture even one cycle early returns a different word within about thirty cycles. A lost turnaround or a late release of chip select shows as a miscount of not-ready cycles before `req_ready` rises.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    typedef enum logic [1:0] {
        OP_CMD       = 2'b00,
        OP_DATA      = 2'b01,
        OP_READ      = 2'b10,
        OP_PANEL_RST = 2'b11
    } pdm_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CS_LEAD,
        ST_WR_SETUP,
        ST_WR_LOW,
        ST_WR_HIGH,
        ST_RD_LOW,
        ST_RD_HIGH,
        ST_CS_TRAIL,
        ST_TURN,
        ST_RST_LOW,
        ST_RST_WAIT
    } pdm_state_e;

    function automatic int pdm_ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int pdm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pdm_timer.sv
module pdm_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pdm_rd_assemble.sv
module pdm_rd_assemble #(
    parameter int BYTE_W  = 8,
    parameter int N_LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  logic                        cap_upper,
    input  logic [BYTE_W-1:0]           byte_in,
    output logic [BYTE_W*N_LANES-1:0]   word_out
);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam bit IS_UPPER = (g == N_LANES - 1);
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (cap_en && (cap_upper == IS_UPPER)) begin
                lane_q <= byte_in;
            end
        end

        assign word_out[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/pdm_fsm.sv
module pdm_fsm
    import pdm_pkg::*;
#(
    parameter int SETUP_CYC    = 1,
    parameter int WR_LOW_CYC   = 3,
    parameter int WR_HIGH_CYC  = 2,
    parameter int RD_ACT_CYC   = 13,
    parameter int RD_HIGH_CYC  = 2,
    parameter int RST_LOW_CYC  = 8,
    parameter int RST_WAIT_CYC = 12,
    parameter int CNT_W        = 4,
    parameter int WORD_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ready,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cap_en,
    output logic              cap_upper,
    output logic              rsp_valid,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_dc_n,
    output logic              bus_rst_n,
    output logic [7:0]        bus_d_out,
    output logic              bus_d_oe
);

    localparam logic [CNT_W-1:0] LD_ONE   = '0;
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WLOW  = CNT_W'(WR_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WHIGH = CNT_W'(WR_HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RLOW  = CNT_W'(RD_ACT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RHIGH = CNT_W'(RD_HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RLO   = CNT_W'(RST_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RWAIT = CNT_W'(RST_WAIT_CYC - 1);

    pdm_state_e        state_q, state_d;
    pdm_op_e           op_q;
    logic [WORD_W-1:0] word_q;
    logic              lo_sel_q;
    logic              accept;
    logic              dc_level;

    assign accept = req_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = (pdm_op_e'(req_op) == OP_PANEL_RST) ? ST_RST_LOW : ST_CS_LEAD;
            ST_CS_LEAD:  state_d = (op_q == OP_READ) ? ST_RD_LOW : ST_WR_SETUP;
            ST_WR_SETUP: if (tmr_expired) state_d = ST_WR_LOW;
            ST_WR_LOW:   if (tmr_expired) state_d = ST_WR_HIGH;
            ST_WR_HIGH:  if (tmr_expired) state_d = lo_sel_q ? ST_CS_TRAIL : ST_WR_SETUP;
            ST_RD_LOW:   if (tmr_expired) state_d = ST_RD_HIGH;
            ST_RD_HIGH:  if (tmr_expired) state_d = lo_sel_q ? ST_CS_TRAIL : ST_RD_LOW;
            ST_CS_TRAIL: state_d = (op_q == OP_READ) ? ST_TURN : ST_IDLE;
            ST_TURN:     state_d = ST_IDLE;
            ST_RST_LOW:  if (tmr_expired) state_d = ST_RST_WAIT;
            ST_RST_WAIT: if (tmr_expired) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // timer load on every state change, with the length of the state entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_WR_SETUP: tmr_val = LD_SETUP;
            ST_WR_LOW:   tmr_val = LD_WLOW;
            ST_WR_HIGH:  tmr_val = LD_WHIGH;
            ST_RD_LOW:   tmr_val = LD_RLOW;
            ST_RD_HIGH:  tmr_val = LD_RHIGH;
            ST_RST_LOW:  tmr_val = LD_RLO;
            ST_RST_WAIT: tmr_val = LD_RWAIT;
            default:     tmr_val = LD_ONE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_CMD;
            word_q   <= '0;
            lo_sel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= pdm_op_e'(req_op);
                word_q <= req_word;
            end
            if (state_q == ST_CS_LEAD) begin
                lo_sel_q <= 1'b0;
            end else if ((state_q == ST_WR_HIGH || state_q == ST_RD_HIGH) && tmr_expired) begin
                lo_sel_q <= 1'b1;
            end
        end
    end

    assign dc_level = (op_q != OP_CMD);

    // outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        cap_en    = 1'b0;
        cap_upper = !lo_sel_q;
        rsp_valid = 1'b0;
        bus_cs_n  = 1'b1;
        bus_wr_n  = 1'b1;
        bus_rd_n  = 1'b1;
        bus_dc_n  = 1'b1;
        bus_rst_n = 1'b1;
        bus_d_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_CS_LEAD:  begin bus_cs_n = 1'b0; bus_dc_n = dc_level; end
            ST_WR_SETUP: begin bus_cs_n = 1'b0; bus_dc_n = dc_level; bus_d_oe = 1'b1; end
            ST_WR_LOW:   begin bus_cs_n = 1'b0; bus_dc_n = dc_level; bus_d_oe = 1'b1; bus_wr_n = 1'b0; end
            ST_WR_HIGH:  begin bus_cs_n = 1'b0; bus_dc_n = dc_level; bus_d_oe = 1'b1; end
            ST_RD_LOW:   begin bus_cs_n = 1'b0; bus_dc_n = dc_level; bus_rd_n = 1'b0; cap_en = tmr_expired; end
            ST_RD_HIGH:  begin bus_cs_n = 1'b0; bus_dc_n = dc_level; end
            ST_CS_TRAIL: begin bus_cs_n = 1'b0; bus_dc_n = dc_level; rsp_valid = (op_q == OP_READ); end
            ST_TURN:     ;
            ST_RST_LOW:  bus_rst_n = 1'b0;
            ST_RST_WAIT: ;
            default:     ;
        endcase
        bus_d_out = bus_d_oe ? (lo_sel_q ? word_q[7:0] : word_q[WORD_W-1:8]) : 8'h00;
    end

    // R6
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_d_oe);

    // R8
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

    // R2
    wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_d_out));

    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> !req_ready);

    // R9
    panel_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |-> (bus_cs_n && bus_wr_n && bus_rd_n && !req_ready));

    // R3
    dc_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_dc_n);

    // R6
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n && !bus_rd_n));

endmodule

// File: rtl/par_disp_master.sv
module par_disp_master
    import pdm_pkg::*;
#(
    parameter int CLK_NS       = 20,
    parameter int WR_LOW_NS    = 50,
    parameter int RD_LOW_NS    = 150,
    parameter int RD_SAMPLE_NS = 250,
    parameter int SETUP_CYC    = 1,
    parameter int WR_HIGH_CYC  = 2,
    parameter int RD_HIGH_CYC  = 2,
    parameter int RST_LOW_CYC  = 8,
    parameter int RST_WAIT_CYC = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic [15:0] req_word,
    output logic        rsp_valid,
    output logic [15:0] rsp_word,
    output logic        bus_cs_n,
    output logic        bus_wr_n,
    output logic        bus_rd_n,
    output logic        bus_dc_n,
    output logic        bus_rst_n,
    output logic [7:0]  bus_d_out,
    output logic        bus_d_oe,
    input  logic [7:0]  bus_d_in
);

    localparam int WR_LOW_CYC = pdm_max(1, pdm_ceil_div(WR_LOW_NS, CLK_NS));
    localparam int RD_ACT_CYC = pdm_max(1, pdm_max(pdm_ceil_div(RD_LOW_NS, CLK_NS),
                                                   pdm_ceil_div(RD_SAMPLE_NS, CLK_NS)));
    localparam int MAX_CYC    = pdm_max(pdm_max(pdm_max(WR_LOW_CYC, RD_ACT_CYC), pdm_max(SETUP_CYC, WR_HIGH_CYC)),
                                        pdm_max(RD_HIGH_CYC, pdm_max(RST_LOW_CYC, RST_WAIT_CYC)));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap_en;
    logic             cap_upper;

    pdm_fsm #(
        .SETUP_CYC   (SETUP_CYC),
        .WR_LOW_CYC  (WR_LOW_CYC),
        .WR_HIGH_CYC (WR_HIGH_CYC),
        .RD_ACT_CYC  (RD_ACT_CYC),
        .RD_HIGH_CYC (RD_HIGH_CYC),
        .RST_LOW_CYC (RST_LOW_CYC),
        .RST_WAIT_CYC(RST_WAIT_CYC),
        .CNT_W       (CNT_W),
        .WORD_W      (16)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_word   (req_word),
        .req_ready  (req_ready),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .cap_en     (cap_en),
        .cap_upper  (cap_upper),
        .rsp_valid  (rsp_valid),
        .bus_cs_n   (bus_cs_n),
        .bus_wr_n   (bus_wr_n),
        .bus_rd_n   (bus_rd_n),
        .bus_dc_n   (bus_dc_n),
        .bus_rst_n  (bus_rst_n),
        .bus_d_out  (bus_d_out),
        .bus_d_oe   (bus_d_oe)
    );

    pdm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    pdm_rd_assemble #(.BYTE_W(8), .N_LANES(2)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_upper(cap_upper),
        .byte_in  (bus_d_in),
        .word_out (rsp_word)
    );

endmodule

// File: tb/par_disp_master_test.sv
`timescale 1ns/1ps
module par_disp_master_test;

    localparam int RD_ACT = 13;
    localparam int WR_LOW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [15:0] req_word = 16'h0;
    logic        rsp_valid;
    logic [15:0] rsp_word;
    logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_dc_n, bus_rst_n, bus_d_oe;
    logic [7:0]  bus_d_out;
    logic [7:0]  bus_d_in = 8'h00;

    par_disp_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_word(req_word), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_dc_n(bus_dc_n),
        .bus_rst_n(bus_rst_n), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // panel model and bus monitor
    int   n_wr, n_rd, rsp_cnt, cs_viol, oe_rd_viol;
    int   wl_cnt, wh_cnt, rl_cnt, cur_pre;
    logic [7:0] cur_b;
    logic cur_dc;
    logic prev_wr = 1'b1, prev_rd = 1'b1;
    logic [7:0] wb_byte [0:7];
    logic       wb_dc   [0:7];
    int         wb_low  [0:7];
    int         wb_pre  [0:7];
    int         rd_low  [0:7];
    logic [7:0] rd_src  [0:1];
    logic [15:0] last_rsp;

    always @(negedge clk) begin
        if ((!bus_wr_n || !bus_rd_n) && bus_cs_n) cs_viol++;
        if (!bus_rd_n && bus_d_oe) oe_rd_viol++;
        if (rsp_valid) begin rsp_cnt++; last_rsp = rsp_word; end
        // write strobes
        if (bus_wr_n && !prev_wr) begin
            if (n_wr < 8) begin
                wb_byte[n_wr] = cur_b; wb_dc[n_wr] = cur_dc;
                wb_low[n_wr] = wl_cnt; wb_pre[n_wr] = cur_pre;
            end
            n_wr++; wl_cnt = 0; wh_cnt = 0;
        end
        if (!bus_wr_n && prev_wr) begin cur_pre = wh_cnt; wh_cnt = 0; end
        if (!bus_wr_n) begin wl_cnt++; cur_b = bus_d_out; cur_dc = bus_dc_n; end
        if (bus_wr_n && bus_d_oe) wh_cnt++;
        if (!bus_d_oe) wh_cnt = 0;
        // read strobes; wrong byte until the sample cycle
        if (bus_rd_n && !prev_rd) begin
            if (n_rd < 8) rd_low[n_rd] = rl_cnt;
            n_rd++; rl_cnt = 0;
        end
        if (!bus_rd_n) begin
            rl_cnt++;
            bus_d_in = (rl_cnt >= RD_ACT) ? rd_src[n_rd % 2] : (~rd_src[n_rd % 2] ^ 8'h3C);
        end
        prev_wr = bus_wr_n;
        prev_rd = bus_rd_n;
    end

    task automatic tick();
        @(negedge clk); #2;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_wr = 0; n_rd = 0; rsp_cnt = 0; cs_viol = 0; oe_rd_viol = 0;
        wl_cnt = 0; wh_cnt = 0; rl_cnt = 0; cur_pre = 0;
    endtask

    int idle_busy, rst_low_seen;

    task automatic issue(input logic [1:0] op, input logic [15:0] w, input bit hold);
        req_op = op; req_word = w; req_valid = 1'b1;
        while (!req_ready) tick();
        tick();
        if (!hold) req_valid = 1'b0;
        idle_busy = 0; rst_low_seen = 0;
        while (!req_ready) begin
            if (!bus_rst_n) rst_low_seen++;
            else if (bus_cs_n) idle_busy++;
            tick();
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 cs_n", bus_cs_n, 1);
        check("R1 wr_n", bus_wr_n, 1);
        check("R1 rd_n", bus_rd_n, 1);
        check("R1 dc_n", bus_dc_n, 1);
        check("R1 rst_n", bus_rst_n, 1);
        check("R1 oe", bus_d_oe, 0);
        check("R1 ready", req_ready, 1);
        check("R1 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_write(input logic [1:0] op, input logic [15:0] w, input bit hold);
        int exp_dc;
        exp_dc = (op == 2'b00) ? 0 : 1;
        clear_logs();
        issue(op, w, hold);
        tick();
        check("R2/R10 strobe count", n_wr, 2);
        check("R2 upper byte first", wb_byte[0], w[15:8]);
        check("R2 lower byte second", wb_byte[1], w[7:0]);
        check("R2 setup cycles", wb_pre[0], 1);
        check("R3 dc first strobe", wb_dc[0], exp_dc);
        check("R3 dc second strobe", wb_dc[1], exp_dc);
        check("R3 dc after word", bus_dc_n, 1);
        check("R4 low width 1", wb_low[0], WR_LOW);
        check("R4 low width 2", wb_low[1], WR_LOW);
        check("R4 inter-byte high", wb_pre[1], 3);
        check("R8 cs with strobe", cs_viol, 0);
        check("R8 cs released", bus_cs_n, 1);
        check("R6 no turnaround after write", idle_busy, 0);
        check("R7 no response on write", rsp_cnt, 0);
    endtask

    task automatic t_read(input logic [15:0] w);
        clear_logs();
        rd_src[0] = w[15:8]; rd_src[1] = w[7:0];
        issue(2'b10, 16'hFFFF, 1'b0);
        tick();
        check("R5 read strobes", n_rd, 2);
        check("R5 read low 1", rd_low[0], RD_ACT);
        check("R5 read low 2", rd_low[1], RD_ACT);
        check("R7 response count", rsp_cnt, 1);
        check("R5 assembled word", last_rsp, w);
        check("R6 bus released on read", oe_rd_viol, 0);
        check("R6 turnaround cycles", idle_busy, 1);
        check("R8 cs with read strobe", cs_viol, 0);
        check("R2 no write strobe on read", n_wr, 0);
    endtask

    task automatic t_panel_reset();
        clear_logs();
        issue(2'b11, 16'h0000, 1'b0);
        check("R9 reset low cycles", rst_low_seen, 8);
        check("R9 recovery cycles", idle_busy, 12);
        check("R9 no strobes", n_wr + n_rd, 0);
        check("R9 cs untouched", cs_viol, 0);
    endtask

    initial begin
        clear_logs();
        rd_src[0] = 8'h00; rd_src[1] = 8'h00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset_state();
        t_write(2'b00, 16'hA55A, 1'b0);   // command
        t_write(2'b01, 16'h1234, 1'b0);   // data
        t_read(16'hBEEF);
        t_write(2'b01, 16'h00FF, 1'b0);   // write after read
        t_read(16'h5A01);
        t_read(16'hC3A7);                 // read after read
        t_panel_reset();
        t_write(2'b01, 16'hE1D2, 1'b1);   // R10: valid held while busy
        t_write(2'b00, 16'h0F80, 1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule